// File: doc/BRIEF.md
# Indirect Register Bus Bridge

This block lets a host reach a narrow internal register bus of 32-bit registers through two 64-bit host CSRs. The host writes one packed command word: an opcode, an internal register address and, for writes, the data. The bridge then runs exactly one transaction on the internal bus. It uses a request/acknowledge handshake, and the responder may hold off the acknowledge for any number of cycles.

When the internal bus acknowledges, the bridge sets a completion flag in the status word. For reads, it also stores the returned data there. The host polls that flag. Completion normally shows up within one or two polls, and a host typically gives up after about ten thousand polls.

Only one command is handled at a time. A command that arrives while a transaction is still in flight is dropped, and a sticky flag in the status word records that it was dropped.

Top module: `irb_bridge`

## Requirements
- R1: After reset the status word reads zero and the internal request `ib_req` is low.
- R2: A host write to byte offset 0x10 is the command port, with this layout: bits 31:0 hold the write data, bits 44:32 hold the internal byte address and bits 63:62 hold the opcode. The address and data of a read or write command appear unchanged on `ib_addr` and `ib_wdata`. Internal registers sit at a stride of 4.
- R3: Opcode 1 (read) drives `ib_we` low. When acknowledged, the bridge places the returned word in status bits 31:0 and sets the valid flag at status bit 32.
- R4: Opcode 2 (write) drives `ib_we` high and sets the valid flag when acknowledged. It leaves status bits 31:0 at the last completed read value.
- R5: Accepting a read or write command clears the valid flag in the next cycle. The flag is set again only by the internal acknowledge of that command.
- R6: Opcodes 0 and 3 are no-operations. They start no internal transaction and leave the status word unchanged.
- R7: `ib_req` is held high, with `ib_we`, `ib_addr` and `ib_wdata` stable, until `ib_ack` is seen. Any number of wait cycles is tolerated.
- R8: A read or write command written while a transaction is in flight is ignored. It sets status bit 33, which stays set until the next accepted command clears it.
- R9: The status word is read at byte offset 0x18. Offset 0x10 reads back the last accepted command, and every other offset reads zero. Host writes to any offset other than 0x10 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 5 | Host CSR byte offset |
| host_wdata | input | 64 | Host write data |
| host_rdata | output | 64 | Host read data for `host_addr` |
| ib_req | output | 1 | Internal transaction request |
| ib_we | output | 1 | 1 = write, 0 = read |
| ib_addr | output | 13 | Internal register byte address |
| ib_wdata | output | 32 | Internal write data |
| ib_rdata | input | 32 | Internal read data, valid with `ib_ack` |
| ib_ack | input | 1 | Internal acknowledge |

## Verification
Several rules are checked on every cycle by assertions:
- the request and its fields hold steady until the acknowledge arrives;
- an accepted command drops the valid flag and raises the request;
- an acknowledge raises the valid flag;
- a rejected command sets the sticky flag;
- an idle no-operation leaves the status unchanged.

Other behaviour can only be shown by the bench's scenarios. These include the returned data matching what was written to each address, and write commands not disturbing the read data. They also include a dropped command not reaching the register file, and the ordering of flags across a sweep of responder wait counts.

// File: rtl/irb_pkg.sv
package irb_pkg;
    typedef enum logic [1:0] {
        OP_NOP   = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2,
        OP_RSVD  = 2'd3
    } irb_op_e;

    localparam int HOST_AW   = 5;
    localparam int REG_DW    = 32;
    localparam int REG_AW    = 13;
    localparam int WORD_W    = 64;
    localparam int OP_LSB    = 62;
    localparam int ADDR_LSB  = 32;
    localparam int VALID_BIT = 32;
    localparam int ERR_BIT   = 33;
endpackage

// File: rtl/irb_cmd_decode.sv
module irb_cmd_decode
    import irb_pkg::*;
#(
    parameter int AW = REG_AW,
    parameter int DW = REG_DW
) (
    input  logic [1:0]    op_raw,
    input  logic [AW-1:0] addr_raw,
    input  logic [DW-1:0] data_raw,
    output logic          is_xfer,
    output logic          is_write,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] data
);
    irb_op_e op;

    always_comb begin
        op       = irb_op_e'(op_raw);
        is_xfer  = (op == OP_READ) || (op == OP_WRITE);
        is_write = (op == OP_WRITE);
        addr     = addr_raw;
        data     = data_raw;
    end
endmodule

// File: rtl/irb_bus_master.sv
module irb_bus_master #(
    parameter int AW = 13,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          start_we,
    input  logic [AW-1:0] start_addr,
    input  logic [DW-1:0] start_data,
    output logic          busy,
    output logic          done,
    output logic          done_read,
    output logic [DW-1:0] done_rdata,
    output logic          ib_req,
    output logic          ib_we,
    output logic [AW-1:0] ib_addr,
    output logic [DW-1:0] ib_wdata,
    input  logic [DW-1:0] ib_rdata,
    input  logic          ib_ack
);
    typedef struct packed {
        logic          busy;
        logic          we;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
    } mst_t;

    mst_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.busy && ib_ack) begin
            st_d.busy = 1'b0;
        end else if (!st_q.busy && start) begin
            st_d.busy  = 1'b1;
            st_d.we    = start_we;
            st_d.addr  = start_addr;
            st_d.wdata = start_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy       = st_q.busy;
    assign done       = st_q.busy && ib_ack;
    assign done_read  = !st_q.we;
    assign done_rdata = ib_rdata;
    assign ib_req     = st_q.busy;
    assign ib_we      = st_q.we;
    assign ib_addr    = st_q.addr;
    assign ib_wdata   = st_q.wdata;

    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ib_req && !ib_ack) |=> (ib_req && $stable(ib_we) && $stable(ib_addr) && $stable(ib_wdata)));

    // R8
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && ib_req && !ib_ack) |=> ($stable(ib_addr) && $stable(ib_wdata)));
endmodule

// File: rtl/irb_bridge.sv
module irb_bridge
    import irb_pkg::*;
#(
    parameter int          HAW        = HOST_AW,
    parameter int          AW         = REG_AW,
    parameter int          DW         = REG_DW,
    parameter logic [4:0]  CMD_OFFSET = 5'h10,
    parameter logic [4:0]  STS_OFFSET = 5'h18
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           host_wr,
    input  logic [HAW-1:0] host_addr,
    input  logic [63:0]    host_wdata,
    output logic [63:0]    host_rdata,
    output logic           ib_req,
    output logic           ib_we,
    output logic [AW-1:0]  ib_addr,
    output logic [DW-1:0]  ib_wdata,
    input  logic [DW-1:0]  ib_rdata,
    input  logic           ib_ack
);
    localparam int STS_PAD = 64 - DW - 2;

    typedef struct packed {
        logic [63:0]   cmd;
        logic [DW-1:0] rdata;
        logic          valid;
        logic          err;
    } csr_t;

    csr_t csr_d, csr_q;

    logic          dec_xfer, dec_write;
    logic [AW-1:0] dec_addr;
    logic [DW-1:0] dec_data;
    logic          m_busy, m_done, m_done_read;
    logic [DW-1:0] m_rdata;
    logic          cmd_hit, accept, reject;
    logic [63:0]   status_word;

    irb_cmd_decode #(.AW(AW), .DW(DW)) u_dec (
        .op_raw   (host_wdata[OP_LSB +: 2]),
        .addr_raw (host_wdata[ADDR_LSB +: AW]),
        .data_raw (host_wdata[DW-1:0]),
        .is_xfer  (dec_xfer),
        .is_write (dec_write),
        .addr     (dec_addr),
        .data     (dec_data)
    );

    assign cmd_hit = host_wr && (host_addr == HAW'(CMD_OFFSET));
    assign accept  = cmd_hit && dec_xfer && !m_busy;
    assign reject  = cmd_hit && dec_xfer && m_busy;

    irb_bus_master #(.AW(AW), .DW(DW)) u_mst (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (cmd_hit && dec_xfer),
        .start_we   (dec_write),
        .start_addr (dec_addr),
        .start_data (dec_data),
        .busy       (m_busy),
        .done       (m_done),
        .done_read  (m_done_read),
        .done_rdata (m_rdata),
        .ib_req     (ib_req),
        .ib_we      (ib_we),
        .ib_addr    (ib_addr),
        .ib_wdata   (ib_wdata),
        .ib_rdata   (ib_rdata),
        .ib_ack     (ib_ack)
    );

    always_comb begin
        csr_d = csr_q;
        if (accept) begin
            csr_d.cmd   = host_wdata;
            csr_d.valid = 1'b0;
            csr_d.err   = 1'b0;
        end else if (reject) begin
            csr_d.err = 1'b1;
        end
        if (m_done) begin
            csr_d.valid = 1'b1;
            if (m_done_read) csr_d.rdata = m_rdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) csr_q <= '0;
        else        csr_q <= csr_d;
    end

    assign status_word = {{STS_PAD{1'b0}}, csr_q.err, csr_q.valid, csr_q.rdata};

    always_comb begin
        host_rdata = '0;
        if (host_addr == HAW'(STS_OFFSET))      host_rdata = status_word;
        else if (host_addr == HAW'(CMD_OFFSET)) host_rdata = csr_q.cmd;
    end

    // R5
    accept_clears_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (!csr_q.valid && ib_req));

    // R5
    ack_sets_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ib_req && ib_ack) |=> csr_q.valid);

    // R6
    nop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_hit && !dec_xfer && !ib_req) |=> ($stable(status_word) && !ib_req));

    // R8
    reject_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reject |=> csr_q.err);
endmodule

// File: tb/tb_irb_bridge.sv
module tb_irb_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [4:0]  host_addr = '0;
    logic [63:0] host_wdata = '0;
    logic [63:0] host_rdata;
    logic        ib_req, ib_we;
    logic [12:0] ib_addr;
    logic [31:0] ib_wdata;
    logic [31:0] ib_rdata = '0;
    logic        ib_ack = 1'b0;

    int n_checks = 0;
    int n_fail = 0;
    int wait_cfg = 0;
    int wcnt = 0;
    int xfers = 0;
    logic [31:0] mem [16];
    logic [31:0] exp_mem [16];

    always #5 clk = ~clk;

    irb_bridge dut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .ib_req(ib_req),
        .ib_we(ib_we), .ib_addr(ib_addr), .ib_wdata(ib_wdata),
        .ib_rdata(ib_rdata), .ib_ack(ib_ack)
    );

    // register-file responder with programmable wait cycles
    always @(posedge clk) begin
        if (!rst_n) begin
            ib_ack <= 1'b0;
            wcnt   <= 0;
        end else begin
            ib_ack <= 1'b0;
            if (ib_req && !ib_ack) begin
                if (wcnt >= wait_cfg) begin
                    ib_ack <= 1'b1;
                    wcnt   <= 0;
                    xfers  <= xfers + 1;
                    if (ib_we) mem[ib_addr[5:2]] <= ib_wdata;
                    else       ib_rdata <= mem[ib_addr[5:2]];
                end else begin
                    wcnt <= wcnt + 1;
                end
            end
        end
    end

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic hwrite(input logic [4:0] a, input logic [63:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hread(input logic [4:0] a, output logic [63:0] d);
        host_addr = a;
        #1;
        d = host_rdata;
    endtask

    function automatic logic [63:0] mkcmd(input logic [1:0] op, input logic [12:0] a, input logic [31:0] d);
        return {op, 17'd0, a, d};
    endfunction

    task automatic poll(output logic [63:0] s, output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 10000; i++) begin
            @(negedge clk);
            hread(5'h18, s);
            if (s[32]) begin ok = 1'b1; break; end
        end
    endtask

    task automatic do_cmd(input logic [1:0] op, input logic [12:0] a, input logic [31:0] d,
                          output logic [63:0] s, output bit ok);
        hwrite(5'h10, mkcmd(op, a, d));
        poll(s, ok);
    endtask

    initial begin
        #1500000;
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [63:0] s, s0;
        bit ok;
        logic [31:0] last_rd;
        int x0;
        for (int i = 0; i < 16; i++) begin mem[i] = '0; exp_mem[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        hread(5'h18, s);
        check(s == 64'd0, "R1 status after reset", s, 64'd0);
        check(ib_req == 1'b0, "R1 req after reset", {63'd0, ib_req}, 64'd0);

        // R2 R3 R4 R7: sweep wait cycles and addresses
        last_rd = '0;
        for (int w = 0; w < 4; w++) begin
            wait_cfg = w;
            for (int i = 0; i < 16; i++) begin
                logic [31:0] v;
                v = 32'hA500_0000 ^ (32'(i) * 32'h0101_0101) ^ 32'(w << 20);
                do_cmd(2'd2, 13'(i * 4), v, s, ok);
                exp_mem[i] = v;
                check(ok && s[31:0] == last_rd, "R4 write keeps read data", s, {32'd1, last_rd});
                do_cmd(2'd1, 13'(i * 4), 32'hFFFF_FFFF, s, ok);
                last_rd = exp_mem[i];
                check(ok && s == {32'd1, exp_mem[i]}, "R3 R2 R7 read returns data", s, {32'd1, exp_mem[i]});
            end
        end

        // R9: command readback and other offsets
        hread(5'h10, s);
        check(s == mkcmd(2'd1, 13'd60, 32'hFFFF_FFFF), "R9 command readback", s, mkcmd(2'd1, 13'd60, 32'hFFFF_FFFF));
        hread(5'h08, s);
        check(s == 64'd0, "R9 other offset reads zero", s, 64'd0);
        hread(5'h18, s0);
        x0 = xfers;
        hwrite(5'h08, mkcmd(2'd2, 13'd4, 32'h1234_5678));
        repeat (6) @(negedge clk);
        hread(5'h18, s);
        check(s == s0 && xfers == x0, "R9 write to other offset ignored", s, s0);

        // R6: no-operation opcodes 0 and 3
        for (int op = 0; op < 4; op += 3) begin
            hwrite(5'h10, mkcmd(2'(op), 13'd8, 32'hDEAD_BEEF));
            repeat (8) @(negedge clk);
            hread(5'h18, s);
            check(s == s0 && xfers == x0 && !ib_req, "R6 nop leaves status", s, s0);
        end

        // R5: valid cleared in cycle after accept, then set by ack
        wait_cfg = 5;
        hwrite(5'h10, mkcmd(2'd1, 13'd12, 32'd0));
        hread(5'h18, s);
        check(s[32] == 1'b0, "R5 valid cleared on accept", s, {31'd0, 1'b0, s[31:0]});
        poll(s, ok);
        check(ok && s == {32'd1, exp_mem[3]}, "R5 valid set on ack", s, {32'd1, exp_mem[3]});

        // R8: command while in flight is dropped, sticky bit set
        wait_cfg = 30;
        x0 = xfers;
        hwrite(5'h10, mkcmd(2'd1, 13'd20, 32'd0));
        @(negedge clk);
        hwrite(5'h10, mkcmd(2'd2, 13'd24, 32'h0BAD_0BAD));
        hread(5'h18, s);
        check(s[33] == 1'b1 && s[32] == 1'b0, "R8 busy flag set", s, 64'h2_0000_0000);
        poll(s, ok);
        check(ok && s == {30'd0, 2'b11, exp_mem[5]}, "R8 first command completes", s, {30'd0, 2'b11, exp_mem[5]});
        check(xfers == x0 + 1, "R8 one transaction only", 64'(xfers), 64'(x0 + 1));
        wait_cfg = 1;
        do_cmd(2'd1, 13'd24, 32'd0, s, ok);
        check(ok && s == {32'd1, exp_mem[6]}, "R8 dropped write absent, flag cleared", s, {32'd1, exp_mem[6]});

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule